// File: doc/BRIEF.md
# 65C02 Shift, Bit and Compare Unit

This unit does the 65C02 operations that do not add or subtract: shifts and rotates, increment and decrement, the three logical operations, the test-and-set and test-and-reset bit operations, bit test in memory and immediate form, single-bit set and clear, and compare against the accumulator or an index register. Each operation has exact processor flag side effects. The unit takes an 8-bit operand, the accumulator, an index register, a bit number, an operation code and the current status byte. It does not access memory or decode instructions. The surrounding datapath already holds these values and routes the result to its destination.

An operation is issued by raising `in_valid` for one clock with the inputs set up. One cycle later the unit presents the result, a write-enable and the updated status byte, and pulses `out_valid`. Operations may be issued on every cycle. When nothing is issued, the registered outputs keep their last values.

The status byte holds N at bit 7, V at bit 6, a constant 1 at bit 5, B at bit 4, D at bit 3, I at bit 2, Z at bit 1 and C at bit 0.

Top module: `sbu_unit`

## Requirements
- R1: The inputs are captured on a rising edge with `in_valid` high. `result`, `wr_en` and `status_out` show the outcome from that edge on, and `out_valid` is high for exactly that cycle. With `in_valid` low, `out_valid` goes low and the other three outputs hold their values.
- R2: Bit 5 of `status_out` is always 1. Every flag that the operation does not name passes through from `status_in`. Undefined codes 17 to 31 return the operand with `wr_en` low and every flag unchanged.
- R3: Code 0 shifts left: C takes operand bit 7 and a zero enters at bit 0. Code 1 shifts right: C takes operand bit 0 and a zero enters at bit 7, so N is always clear. Both set N and Z from the 8-bit result.
- R4: Code 2 rotates left and puts the incoming C at bit 0, with C taking operand bit 7. Code 3 rotates right and puts the incoming C at bit 7, with C taking operand bit 0. Both set N and Z from the result.
- R5: Code 4 adds one to the operand and code 5 subtracts one. Both wrap modulo 256 and change only N and Z.
- R6: Codes 6, 7 and 8 return the accumulator OR, AND and XOR the operand. They change only N and Z.
- R7: Code 9 returns operand OR accumulator. Code 10 returns operand AND NOT accumulator. Both set Z when accumulator AND operand is zero and change no other flag.
- R8: Code 11, the memory bit test, sets Z when accumulator AND operand is zero, copies operand bit 7 to N and copies operand bit 6 to V. Code 12, the immediate bit test, changes only Z by the same rule. Both return the operand unchanged.
- R9: Code 13 sets operand bit `bit_sel` and code 14 clears it. No flag changes.
- R10: Code 15 compares the accumulator and code 16 compares `idx` against the operand. The result is register minus operand modulo 256. N and Z are set from that difference, and C is set when the register is at least the operand unsigned.
- R11: `wr_en` is low for codes 11, 12, 15 and 16 and high for codes 0 to 10, 13 and 14.
- R12: After reset `out_valid` is 0, `result` is 0, `wr_en` is 0 and `status_out` is 8'h20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue an operation this cycle |
| op | input | 5 | Operation code (see requirements) |
| operand | input | 8 | Memory or immediate operand |
| acc | input | 8 | Accumulator value |
| idx | input | 8 | Index register value for compare code 16 |
| bit_sel | input | 3 | Bit number for set/clear bit |
| status_in | input | 8 | Current status byte |
| out_valid | output | 1 | Result of the previous cycle's issue |
| result | output | 8 | Value to write back |
| wr_en | output | 1 | Result should be written back |
| status_out | output | 8 | Updated status byte |

## Verification
Capture of a new operation and presentation of the previous result happen in the same cycle whenever operations are issued back to back. The bench provokes this with long runs where `in_valid` never drops, mixed with random single idle gaps. Each run carries an unrelated status byte, so a rotate consumes the carry it was handed and not the one just produced. A queue holds one expected item per issue and pairs it with each `out_valid` pulse in order. Dropped, duplicated or stale results therefore show up as mismatches. The bench also drives the inputs while idle to confirm that the outputs hold.

// File: rtl/sbu_pkg.sv
`timescale 1ns/1ps
package sbu_pkg;
  localparam int DW    = 8;
  localparam int BW    = $clog2(DW);
  localparam int OPW   = 5;
  localparam int F_C   = 0;
  localparam int F_Z   = 1;
  localparam int F_ONE = 5;
  localparam int F_V   = 6;
  localparam int F_N   = 7;

  typedef enum logic [OPW-1:0] {
    OP_ASL  = 5'd0,
    OP_LSR  = 5'd1,
    OP_ROL  = 5'd2,
    OP_ROR  = 5'd3,
    OP_INC  = 5'd4,
    OP_DEC  = 5'd5,
    OP_ORA  = 5'd6,
    OP_AND  = 5'd7,
    OP_EOR  = 5'd8,
    OP_TSB  = 5'd9,
    OP_TRB  = 5'd10,
    OP_BITM = 5'd11,
    OP_BITI = 5'd12,
    OP_SMB  = 5'd13,
    OP_RMB  = 5'd14,
    OP_CPA  = 5'd15,
    OP_CPI  = 5'd16
  } sbu_op_e;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          wr;
    logic          n_en;
    logic          n;
    logic          v_en;
    logic          v;
    logic          z_en;
    logic          z;
    logic          c_en;
    logic          c;
  } sbu_upd_t;
endpackage

// File: rtl/sbu_shift.sv
`timescale 1ns/1ps
module sbu_shift
  import sbu_pkg::*;
(
  input  sbu_op_e        op,
  input  logic [DW-1:0]  opnd,
  input  logic           c_in,
  output sbu_upd_t       upd
);
  always_comb begin
    upd      = '0;
    upd.wr   = 1'b1;
    upd.n_en = 1'b1;
    upd.z_en = 1'b1;
    upd.res  = opnd;
    case (op)
      OP_ASL: begin
        upd.res  = {opnd[DW-2:0], 1'b0};
        upd.c_en = 1'b1;
        upd.c    = opnd[DW-1];
      end
      OP_LSR: begin
        upd.res  = {1'b0, opnd[DW-1:1]};
        upd.c_en = 1'b1;
        upd.c    = opnd[0];
      end
      OP_ROL: begin
        upd.res  = {opnd[DW-2:0], c_in};
        upd.c_en = 1'b1;
        upd.c    = opnd[DW-1];
      end
      OP_ROR: begin
        upd.res  = {c_in, opnd[DW-1:1]};
        upd.c_en = 1'b1;
        upd.c    = opnd[0];
      end
      OP_INC:  upd.res = opnd + DW'(1);
      OP_DEC:  upd.res = opnd - DW'(1);
      default: upd.res = opnd;
    endcase
    upd.n = upd.res[DW-1];
    upd.z = ~|upd.res;
  end
endmodule

// File: rtl/sbu_logic.sv
`timescale 1ns/1ps
module sbu_logic
  import sbu_pkg::*;
(
  input  sbu_op_e        op,
  input  logic [DW-1:0]  opnd,
  input  logic [DW-1:0]  acc,
  input  logic [BW-1:0]  bit_sel,
  output sbu_upd_t       upd
);
  logic [DW-1:0] one_hot;
  logic          test_zero;

  assign one_hot   = DW'(1) << bit_sel;
  assign test_zero = ~|(acc & opnd);

  always_comb begin
    upd     = '0;
    upd.res = opnd;
    case (op)
      OP_ORA, OP_AND, OP_EOR: begin
        case (op)
          OP_ORA:  upd.res = acc | opnd;
          OP_AND:  upd.res = acc & opnd;
          default: upd.res = acc ^ opnd;
        endcase
        upd.wr   = 1'b1;
        upd.n_en = 1'b1;
        upd.n    = upd.res[DW-1];
        upd.z_en = 1'b1;
        upd.z    = ~|upd.res;
      end
      OP_TSB, OP_TRB: begin
        upd.res  = (op == OP_TSB) ? (opnd | acc) : (opnd & ~acc);
        upd.wr   = 1'b1;
        upd.z_en = 1'b1;
        upd.z    = test_zero;
      end
      OP_BITM: begin
        upd.z_en = 1'b1;
        upd.z    = test_zero;
        upd.n_en = 1'b1;
        upd.n    = opnd[F_N];
        upd.v_en = 1'b1;
        upd.v    = opnd[F_V];
      end
      OP_BITI: begin
        upd.z_en = 1'b1;
        upd.z    = test_zero;
      end
      OP_SMB: begin
        upd.res = opnd | one_hot;
        upd.wr  = 1'b1;
      end
      OP_RMB: begin
        upd.res = opnd & ~one_hot;
        upd.wr  = 1'b1;
      end
      default: upd.res = opnd;
    endcase
  end
endmodule

// File: rtl/sbu_cmp.sv
`timescale 1ns/1ps
module sbu_cmp
  import sbu_pkg::*;
(
  input  sbu_op_e        op,
  input  logic [DW-1:0]  opnd,
  input  logic [DW-1:0]  acc,
  input  logic [DW-1:0]  idx,
  output sbu_upd_t       upd
);
  logic [DW-1:0] lhs;
  logic [DW:0]   diff_ext;

  assign lhs      = (op == OP_CPI) ? idx : acc;
  assign diff_ext = {1'b0, lhs} - {1'b0, opnd};

  always_comb begin
    upd      = '0;
    upd.res  = diff_ext[DW-1:0];
    upd.n_en = 1'b1;
    upd.n    = diff_ext[DW-1];
    upd.z_en = 1'b1;
    upd.z    = ~|diff_ext[DW-1:0];
    upd.c_en = 1'b1;
    upd.c    = ~diff_ext[DW];
  end
endmodule

// File: rtl/sbu_unit.sv
`timescale 1ns/1ps
module sbu_unit
  import sbu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [4:0]     op,
  input  logic [7:0]     operand,
  input  logic [7:0]     acc,
  input  logic [7:0]     idx,
  input  logic [2:0]     bit_sel,
  input  logic [7:0]     status_in,
  output logic           out_valid,
  output logic [7:0]     result,
  output logic           wr_en,
  output logic [7:0]     status_out
);
  localparam logic [DW-1:0] ST_RESET = DW'(1) << F_ONE;

  logic    rst_meta, rst_q;
  sbu_op_e op_e;
  sbu_upd_t u_sh, u_lg, u_cp, u_sel;
  logic [DW-1:0] st_nxt;

  assign op_e = sbu_op_e'(op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  sbu_shift i_shift (.op(op_e), .opnd(operand), .c_in(status_in[F_C]), .upd(u_sh));
  sbu_logic i_logic (.op(op_e), .opnd(operand), .acc(acc), .bit_sel(bit_sel), .upd(u_lg));
  sbu_cmp   i_cmp   (.op(op_e), .opnd(operand), .acc(acc), .idx(idx), .upd(u_cp));

  always_comb begin
    u_sel     = '0;
    u_sel.res = operand;
    case (op_e)
      OP_ASL, OP_LSR, OP_ROL, OP_ROR, OP_INC, OP_DEC: u_sel = u_sh;
      OP_ORA, OP_AND, OP_EOR, OP_TSB, OP_TRB,
      OP_BITM, OP_BITI, OP_SMB, OP_RMB:             u_sel = u_lg;
      OP_CPA, OP_CPI:                               u_sel = u_cp;
      default: begin
        u_sel     = '0;
        u_sel.res = operand;
      end
    endcase
  end

  always_comb begin
    st_nxt = status_in;
    if (u_sel.n_en) st_nxt[F_N] = u_sel.n;
    if (u_sel.v_en) st_nxt[F_V] = u_sel.v;
    if (u_sel.z_en) st_nxt[F_Z] = u_sel.z;
    if (u_sel.c_en) st_nxt[F_C] = u_sel.c;
    st_nxt[F_ONE] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid  <= 1'b0;
      result     <= '0;
      wr_en      <= 1'b0;
      status_out <= ST_RESET;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= u_sel.res;
        wr_en      <= u_sel.wr;
        status_out <= st_nxt;
      end
    end
  end

  // R1: issue produces one valid cycle, idle produces none and holds data
  p_issue_r1: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> (!out_valid && $stable(result) && $stable(status_out) && $stable(wr_en)));
  // R2: constant one in status
  p_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> status_out[F_ONE]);
  // R3: right shift never leaves N set
  p_lsr_neg_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && op_e == OP_LSR) |=> !status_out[F_N]);
  // R5: increment/decrement leave V and C alone
  p_incdec_vc_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && (op_e == OP_INC || op_e == OP_DEC)) |=>
      (status_out[F_V] == $past(status_in[F_V]) && status_out[F_C] == $past(status_in[F_C])));
  // R8: immediate bit test keeps N, V, C
  p_biti_z_only_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && op_e == OP_BITI) |=>
      (status_out[F_N] == $past(status_in[F_N]) && status_out[F_V] == $past(status_in[F_V]) &&
       status_out[F_C] == $past(status_in[F_C])));
  // R9: bit set/clear changes no flag
  p_bitset_flags_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && (op_e == OP_SMB || op_e == OP_RMB)) |=>
      (status_out == ($past(status_in) | ST_RESET)));
  // R11: tests and compares never request a write
  p_no_write_r11: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && (op_e == OP_BITM || op_e == OP_BITI || op_e == OP_CPA || op_e == OP_CPI))
      |=> !wr_en);
endmodule

// File: tb/test_sbu_unit.sv
`timescale 1ns/1ps
module test_sbu_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [4:0] op;
  logic [7:0] operand, acc, idx, status_in;
  logic [2:0] bit_sel;
  logic       out_valid;
  logic [7:0] result;
  logic       wr_en;
  logic [7:0] status_out;

  typedef struct {
    logic [16:0] exp;
    string       tag;
  } item_t;

  item_t       q[$];
  item_t       it_m;
  logic [16:0] last_exp;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbu_unit i_sbu_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .operand(operand),
    .acc(acc), .idx(idx), .bit_sel(bit_sel), .status_in(status_in),
    .out_valid(out_valid), .result(result), .wr_en(wr_en), .status_out(status_out)
  );

  // Reference: {result, wr_en, status}
  function automatic logic [16:0] model(input logic [4:0] o, input logic [7:0] m, a, x,
                                        input logic [2:0] n, input logic [7:0] p);
    logic [7:0] r, s;
    logic       w;
    int         d;
    s = p;
    r = m;
    w = 1'b1;
    case (o)
      5'd0: begin r = m << 1; s[0] = m[7]; end
      5'd1: begin r = m >> 1; s[0] = m[0]; end
      5'd2: begin r = {m[6:0], p[0]}; s[0] = m[7]; end
      5'd3: begin r = {p[0], m[7:1]}; s[0] = m[0]; end
      5'd4: r = 8'(m + 8'd1);
      5'd5: r = 8'(m - 8'd1);
      5'd6: r = a | m;
      5'd7: r = a & m;
      5'd8: r = a ^ m;
      5'd9:  begin r = m | a;  s[1] = ((a & m) == 8'h00); end
      5'd10: begin r = m & ~a; s[1] = ((a & m) == 8'h00); end
      5'd11: begin w = 1'b0; s[1] = ((a & m) == 8'h00); s[7] = m[7]; s[6] = m[6]; end
      5'd12: begin w = 1'b0; s[1] = ((a & m) == 8'h00); end
      5'd13: r = m | (8'h01 << n);
      5'd14: r = m & ~(8'h01 << n);
      5'd15, 5'd16: begin
        d = (o == 5'd15) ? (int'(a) - int'(m)) : (int'(x) - int'(m));
        r = 8'(d);
        w = 1'b0;
        s[0] = (d >= 0);
      end
      default: w = 1'b0;
    endcase
    if (o <= 5'd8 || o == 5'd15 || o == 5'd16) begin
      s[7] = r[7];
      s[1] = (r == 8'h00);
    end
    s[5] = 1'b1;
    return {r, w, s};
  endfunction

  function automatic string tag_of(input logic [4:0] o);
    case (o)
      5'd0, 5'd1:   return "R3";
      5'd2, 5'd3:   return "R4";
      5'd4, 5'd5:   return "R5";
      5'd6, 5'd7, 5'd8: return "R6";
      5'd9, 5'd10:  return "R7";
      5'd11, 5'd12: return "R8/R11";
      5'd13, 5'd14: return "R9";
      5'd15, 5'd16: return "R10/R11";
      default:      return "R2";
    endcase
  endfunction

  task automatic chk(input logic [16:0] act, input logic [16:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual {res,wr,st}=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] o, input logic [7:0] m, a, x,
                       input logic [2:0] n, input logic [7:0] p);
    item_t it;
    @(negedge clk);
    op = o; operand = m; acc = a; idx = x; bit_sel = n; status_in = p;
    in_valid = 1'b1;
    it.exp = model(o, m, a, x, n, p);
    it.tag = tag_of(o);
    last_exp = it.exp;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: pair each output pulse with the oldest expected item
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        chk({result, wr_en, status_out}, 17'h0, "R1 (no item queued)");
        n_fail += (result == 8'h0 && !wr_en && status_out == 8'h0) ? 1 : 0;
      end else begin
        it_m = q.pop_front();
        chk({result, wr_en, status_out}, it_m.exp, it_m.tag);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1: watchdog expired, actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; operand = '0; acc = '0; idx = '0;
    bit_sel = '0; status_in = '0; last_exp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk({result, wr_en, status_out}, {8'h00, 1'b0, 8'h20}, "R12");
    chk({16'h0, out_valid}, 17'h0, "R12 out_valid");

    // Directed corners
    issue(5'd1, 8'h81, 8'h00, 8'h00, 3'd0, 8'hFF);   // R3: LSR, N forced clear, C=1
    issue(5'd0, 8'h80, 8'h00, 8'h00, 3'd0, 8'h00);   // R3: ASL to zero
    issue(5'd3, 8'h00, 8'h00, 8'h00, 3'd0, 8'h01);   // R4: ROR pulls C into bit 7
    issue(5'd4, 8'hFF, 8'h00, 8'h00, 3'd0, 8'h41);   // R5: INC wrap, V/C kept
    issue(5'd5, 8'h00, 8'h00, 8'h00, 3'd0, 8'h00);   // R5: DEC wrap
    issue(5'd9, 8'h0F, 8'hF0, 8'h00, 3'd0, 8'h80);   // R7: TSB disjoint -> Z
    issue(5'd10, 8'hFF, 8'h0F, 8'h00, 3'd0, 8'h02);  // R7: TRB overlap -> Z clear
    issue(5'd11, 8'hC0, 8'h3F, 8'h00, 3'd0, 8'h00);  // R8: BIT mem N,V from operand
    issue(5'd12, 8'hC0, 8'h40, 8'h00, 3'd0, 8'hC3);  // R8: BIT imm only Z
    issue(5'd13, 8'h00, 8'h00, 8'h00, 3'd7, 8'hDB);  // R9
    issue(5'd14, 8'hFF, 8'h00, 8'h00, 3'd0, 8'h24);  // R9
    issue(5'd15, 8'h10, 8'h10, 8'h00, 3'd0, 8'h00);  // R10 equal
    issue(5'd16, 8'h01, 8'hFF, 8'h00, 3'd0, 8'h01);  // R10 idx below
    issue(5'd20, 8'h5A, 8'hFF, 8'hFF, 3'd1, 8'h9D);  // R2 undefined code
    idle();

    // Full operand sweep for shifts/rotates with both carry values (R3, R4)
    for (int o = 0; o < 4; o++)
      for (int c = 0; c < 2; c++)
        for (int m = 0; m < 256; m++) begin
          issue(5'(o), 8'(m), 8'($urandom), 8'($urandom), 3'($urandom),
                {7'($urandom), 1'(c)});
          if (m % 97 == 0) idle();
        end
    idle();

    // Random mix, back to back with occasional gaps (R2, R5-R11)
    for (int k = 0; k < 4000; k++) begin
      issue(5'($urandom_range(0, 20)), 8'($urandom), 8'($urandom), 8'($urandom),
            3'($urandom), 8'($urandom));
      if ($urandom_range(0, 3) == 0) idle();
    end
    idle();
    idle();
    chk({16'h0, (q.size() != 0)}, 17'h0, "R1 queue drained");

    // R1 hold: inputs change while idle, outputs keep last result
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      op = 5'($urandom); operand = 8'($urandom); acc = 8'($urandom);
      status_in = 8'($urandom);
      @(negedge clk);
      chk({result, wr_en, status_out}, last_exp, "R1 hold");
      chk({16'h0, out_valid}, 17'h0, "R1 idle valid");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule